// File: doc/BRIEF.md
# Asynchronous Transfer Tracker with Read and Write Barriers

This block sits between a small processor core and the request port of an on-chip network. The core hands it read and write transfer requests. Each request names a remote target by x and y grid coordinates plus an address local to that target, and a local buffer address. A legal request is forwarded to the network in the same cycle it is presented, so the core is never held while data moves. The block keeps one outstanding count for reads and a separate one for writes. Completion pulses for each kind may come back in any order relative to issue, and each pulse retires one transfer of its kind.

The core can raise a read barrier or a write barrier at any time. While a barrier is held and its own counter is not yet zero, the block stalls the core. Once the counter has been zero on a clock edge with the barrier held, the matching done flag rises and the stall for that barrier drops. Reads and writes never wait on each other's barrier.

Only shared memory may act as the local end of a transfer. A base/limit pair marks the core-private window. A request whose local buffer address falls inside that window is consumed and dropped, never forwarded, and a sticky error flag records that it happened.

Top module: `async_xfer_tracker`

## Requirements
- R1: After reset both outstanding counts are 0, the error flag is 0, both barrier done flags are 0, core_stall is 0, and with req_valid low noc_valid is 0.
- R2: A request with req_valid high, a local address outside the private window and a non-full counter for its kind (req_write 0 = read, 1 = write) drives noc_valid high in the same cycle. When noc_ready is also high, the transfer is issued and the matching count rises by one at the next clock edge.
- R3: A counter holds at most 255. When the counter for the request's kind is 255, noc_valid and req_ready are both low, and the count stays 255 until a completion arrives.
- R4: A pulse on cpl_rd (cpl_wr) lowers the read (write) count by one at the next edge. Completions carry no tag, so any return order is accepted. A completion while the count is 0 is ignored and the count stays 0.
- R5: When a transfer of one kind issues in the same cycle as a completion of that kind, that count is unchanged.
- R6: rd_barrier_done is high in a cycle exactly when, at the previous edge, rd_barrier was high and the read count was 0. A barrier raised while the count is already 0 therefore releases on the next cycle.
- R7: The write barrier behaves as in R6 using only the write count. Outstanding reads never delay it, and outstanding writes never delay the read barrier.
- R8: A request whose local address lies in the inclusive range [priv_base, priv_limit] is not forwarded (noc_valid low). It is accepted (req_ready high), it changes neither count, and it sets priv_error from the next edge on. priv_error stays set until reset.
- R9: core_stall is high exactly when some barrier input is high while its done flag is low.
- R10: noc_write, noc_x, noc_y, noc_raddr and noc_laddr equal the request fields of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a transfer request |
| req_write | input | 1 | 0 = read, 1 = write |
| req_x | input | 6 | Remote target column |
| req_y | input | 6 | Remote target row |
| req_raddr | input | 32 | Address inside the remote target |
| req_laddr | input | 20 | Local buffer address |
| req_ready | output | 1 | Request consumed this cycle (issued or dropped) |
| priv_base | input | 20 | First address of the private window |
| priv_limit | input | 20 | Last address of the private window |
| noc_valid | output | 1 | Request offered to the network |
| noc_write | output | 1 | Kind of the offered request |
| noc_x | output | 6 | Offered target column |
| noc_y | output | 6 | Offered target row |
| noc_raddr | output | 32 | Offered remote address |
| noc_laddr | output | 20 | Offered local address |
| noc_ready | input | 1 | Network accepts the offered request |
| cpl_rd | input | 1 | One read has completed |
| cpl_wr | input | 1 | One write has completed |
| rd_barrier | input | 1 | Core waits for all reads |
| wr_barrier | input | 1 | Core waits for all writes |
| rd_barrier_done | output | 1 | Read barrier satisfied |
| wr_barrier_done | output | 1 | Write barrier satisfied |
| core_stall | output | 1 | Core must hold |
| rd_outstanding | output | 8 | Reads in flight |
| wr_outstanding | output | 8 | Writes in flight |
| priv_error | output | 1 | Sticky: a private-window request was dropped |

## Verification
The hardest condition to reach is a saturated counter. The bench gets there by issuing 260 back-to-back reads with no completions, so the read count pins at 255. While that count is pinned, it raises the write barrier and then the read barrier. This shows that the write barrier releases with the read side full, and that the stall holds until the read side drains. A long random phase produces unordered completion pulses, completions at count zero, and issue/completion collisions. The private-window phase probes the addresses one below the window, at its base and at its limit.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
   typedef enum logic {
      XFER_RD = 1'b0,
      XFER_WR = 1'b1
   } xfer_kind_e;

   localparam int unsigned XFER_KINDS = 2;
endpackage

// File: rtl/xfer_outstanding_ctr.sv
module xfer_outstanding_ctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             zero
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_width
      $error("xfer_outstanding_ctr: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc && !dec && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (dec && !inc && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign count = cnt_q;
   assign full  = (cnt_q == CNT_MAX);
   assign zero  = (cnt_q == '0);
endmodule

// File: rtl/xfer_priv_guard.sv
module xfer_priv_guard #(
   parameter int unsigned LADDR_W = 20
) (
   input  logic [LADDR_W-1:0] addr,
   input  logic [LADDR_W-1:0] base,
   input  logic [LADDR_W-1:0] limit,
   output logic               hit
);
   if (LADDR_W < 1) begin : g_bad_width
      $error("xfer_priv_guard: LADDR_W must be positive");
   end

   assign hit = (addr >= base) && (addr <= limit);
endmodule

// File: rtl/xfer_barrier_gate.sv
module xfer_barrier_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic bar_req,
   input  logic cnt_zero,
   output logic done,
   output logic stall
);
   logic done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else begin
         done_q <= bar_req && cnt_zero;
      end
   end

   assign done  = done_q;
   assign stall = bar_req && !done_q;
endmodule

// File: rtl/async_xfer_tracker.sv
module async_xfer_tracker #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned X_W     = 6,
   parameter int unsigned Y_W     = 6,
   parameter int unsigned RADDR_W = 32,
   parameter int unsigned LADDR_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [X_W-1:0]     req_x,
   input  logic [Y_W-1:0]     req_y,
   input  logic [RADDR_W-1:0] req_raddr,
   input  logic [LADDR_W-1:0] req_laddr,
   output logic               req_ready,
   input  logic [LADDR_W-1:0] priv_base,
   input  logic [LADDR_W-1:0] priv_limit,
   output logic               noc_valid,
   output logic               noc_write,
   output logic [X_W-1:0]     noc_x,
   output logic [Y_W-1:0]     noc_y,
   output logic [RADDR_W-1:0] noc_raddr,
   output logic [LADDR_W-1:0] noc_laddr,
   input  logic               noc_ready,
   input  logic               cpl_rd,
   input  logic               cpl_wr,
   input  logic               rd_barrier,
   input  logic               wr_barrier,
   output logic               rd_barrier_done,
   output logic               wr_barrier_done,
   output logic               core_stall,
   output logic [CNT_W-1:0]   rd_outstanding,
   output logic [CNT_W-1:0]   wr_outstanding,
   output logic               priv_error
);
   import xfer_pkg::*;

   if (X_W < 1 || Y_W < 1 || RADDR_W < 1) begin : g_bad_fields
      $error("async_xfer_tracker: field widths must be positive");
   end

   logic                   priv_hit;
   logic                   sel_full;
   logic                   issue;
   logic                   err_q;
   logic [XFER_KINDS-1:0]  kind_full;
   logic [XFER_KINDS-1:0]  kind_zero;
   logic [XFER_KINDS-1:0]  kind_done;
   logic [XFER_KINDS-1:0]  kind_stall;
   logic [XFER_KINDS-1:0]  kind_cpl;
   logic [XFER_KINDS-1:0]  kind_bar;
   logic [CNT_W-1:0]       kind_cnt [XFER_KINDS];

   assign kind_cpl = {cpl_wr, cpl_rd};
   assign kind_bar = {wr_barrier, rd_barrier};

   xfer_priv_guard #(.LADDR_W(LADDR_W)) u_guard (
      .addr  (req_laddr),
      .base  (priv_base),
      .limit (priv_limit),
      .hit   (priv_hit)
   );

   assign sel_full  = kind_full[req_write];
   assign noc_valid = req_valid && !priv_hit && !sel_full;
   assign issue     = noc_valid && noc_ready;
   assign req_ready = priv_hit || (noc_ready && !sel_full);

   for (genvar k = 0; k < XFER_KINDS; k++) begin : g_kind
      xfer_outstanding_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (issue && (req_write == k[0])),
         .dec   (kind_cpl[k]),
         .count (kind_cnt[k]),
         .full  (kind_full[k]),
         .zero  (kind_zero[k])
      );

      xfer_barrier_gate u_bar (
         .clk      (clk),
         .rst_n    (rst_n),
         .bar_req  (kind_bar[k]),
         .cnt_zero (kind_zero[k]),
         .done     (kind_done[k]),
         .stall    (kind_stall[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (req_valid && priv_hit) begin
         err_q <= 1'b1;
      end
   end

   assign noc_write       = req_write;
   assign noc_x           = req_x;
   assign noc_y           = req_y;
   assign noc_raddr       = req_raddr;
   assign noc_laddr       = req_laddr;
   assign rd_outstanding  = kind_cnt[XFER_RD];
   assign wr_outstanding  = kind_cnt[XFER_WR];
   assign rd_barrier_done = kind_done[XFER_RD];
   assign wr_barrier_done = kind_done[XFER_WR];
   assign core_stall      = |kind_stall;
   assign priv_error      = err_q;
endmodule

// File: rtl/xfer_tracker_checker.sv
module xfer_tracker_checker #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned LADDR_W = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [LADDR_W-1:0] req_laddr,
   input logic [LADDR_W-1:0] priv_base,
   input logic [LADDR_W-1:0] priv_limit,
   input logic               noc_valid,
   input logic               noc_ready,
   input logic               noc_write,
   input logic               cpl_rd,
   input logic               rd_barrier,
   input logic               wr_barrier,
   input logic [CNT_W-1:0]   rd_outstanding,
   input logic [CNT_W-1:0]   wr_outstanding,
   input logic               rd_barrier_done,
   input logic               wr_barrier_done,
   input logic               priv_error
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_outstanding == CNT_MAX) |-> !(noc_valid && !noc_write));

   assert_priv_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_laddr >= priv_base && req_laddr <= priv_limit) |-> !noc_valid);

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      priv_error |=> priv_error);

   assert_collide_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (noc_valid && noc_ready && !noc_write && cpl_rd) |=> $stable(rd_outstanding));

   assert_rd_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_barrier && rd_outstanding == '0) |=> rd_barrier_done);

   assert_wr_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_barrier && wr_outstanding == '0) |=> wr_barrier_done);
endmodule

bind async_xfer_tracker xfer_tracker_checker #(.CNT_W(CNT_W), .LADDR_W(LADDR_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_valid       (req_valid),
   .req_laddr       (req_laddr),
   .priv_base       (priv_base),
   .priv_limit      (priv_limit),
   .noc_valid       (noc_valid),
   .noc_ready       (noc_ready),
   .noc_write       (noc_write),
   .cpl_rd          (cpl_rd),
   .rd_barrier      (rd_barrier),
   .wr_barrier      (wr_barrier),
   .rd_outstanding  (rd_outstanding),
   .wr_outstanding  (wr_outstanding),
   .rd_barrier_done (rd_barrier_done),
   .wr_barrier_done (wr_barrier_done),
   .priv_error      (priv_error)
);

// File: tb/async_xfer_tracker_bench.sv
`timescale 1ns/1ps
module async_xfer_tracker_bench;
   localparam int MAXC = 255;
   localparam logic [19:0] PBASE  = 20'h0F000;
   localparam logic [19:0] PLIMIT = 20'h0FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [5:0]  req_x = '0, req_y = '0;
   logic [31:0] req_raddr = '0;
   logic [19:0] req_laddr = '0;
   logic        req_ready;
   logic [19:0] priv_base = PBASE, priv_limit = PLIMIT;
   logic        noc_valid, noc_write;
   logic [5:0]  noc_x, noc_y;
   logic [31:0] noc_raddr;
   logic [19:0] noc_laddr;
   logic        noc_ready = 1'b0;
   logic        cpl_rd = 1'b0, cpl_wr = 1'b0;
   logic        rd_barrier = 1'b0, wr_barrier = 1'b0;
   logic        rd_barrier_done, wr_barrier_done, core_stall;
   logic [7:0]  rd_outstanding, wr_outstanding;
   logic        priv_error;

   int checks = 0;
   int errors = 0;
   bit done_run = 0;

   int m_cnt [2];
   bit m_done [2];
   bit m_err;

   always #2.5 clk = ~clk;

   async_xfer_tracker u_async_xfer_tracker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_x(req_x), .req_y(req_y), .req_raddr(req_raddr), .req_laddr(req_laddr),
      .req_ready(req_ready), .priv_base(priv_base), .priv_limit(priv_limit),
      .noc_valid(noc_valid), .noc_write(noc_write), .noc_x(noc_x), .noc_y(noc_y),
      .noc_raddr(noc_raddr), .noc_laddr(noc_laddr), .noc_ready(noc_ready),
      .cpl_rd(cpl_rd), .cpl_wr(cpl_wr), .rd_barrier(rd_barrier), .wr_barrier(wr_barrier),
      .rd_barrier_done(rd_barrier_done), .wr_barrier_done(wr_barrier_done),
      .core_stall(core_stall), .rd_outstanding(rd_outstanding),
      .wr_outstanding(wr_outstanding), .priv_error(priv_error)
   );

   function automatic bit in_priv(input logic [19:0] a);
      return (a >= priv_base) && (a <= priv_limit);
   endfunction

   // reference model: updated on each rising edge from the inputs held there
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt[0] = 0; m_cnt[1] = 0; m_done[0] = 0; m_done[1] = 0; m_err = 0;
      end else begin
         bit hit, fire;
         int d;
         bit cpl [2];
         hit  = in_priv(req_laddr);
         d    = int'(req_write);
         fire = req_valid && !hit && (m_cnt[d] < MAXC) && noc_ready;
         cpl[0] = cpl_rd; cpl[1] = cpl_wr;
         m_done[0] = rd_barrier && (m_cnt[0] == 0);
         m_done[1] = wr_barrier && (m_cnt[1] == 0);
         for (int k = 0; k < 2; k++) begin
            bit inc;
            inc = fire && (d == k);
            if (inc && !cpl[k]) m_cnt[k]++;
            else if (cpl[k] && !inc && m_cnt[k] > 0) m_cnt[k]--;
         end
         if (req_valid && hit) m_err = 1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      bit hit, full, ev;
      hit  = in_priv(req_laddr);
      full = m_cnt[int'(req_write)] >= MAXC;
      ev   = req_valid && !hit && !full;
      chk("R4 rd_outstanding", int'(rd_outstanding), m_cnt[0]);
      chk("R4 wr_outstanding", int'(wr_outstanding), m_cnt[1]);
      chk("R6 rd_barrier_done", int'(rd_barrier_done), int'(m_done[0]));
      chk("R7 wr_barrier_done", int'(wr_barrier_done), int'(m_done[1]));
      chk("R9 core_stall", int'(core_stall),
          int'((rd_barrier && !m_done[0]) || (wr_barrier && !m_done[1])));
      chk("R8 priv_error", int'(priv_error), int'(m_err));
      chk("R2 noc_valid", int'(noc_valid), int'(ev));
      chk("R3 req_ready", int'(req_ready), int'(hit || (noc_ready && !full)));
      if (ev) begin
         chk("R10 noc_x", int'(noc_x), int'(req_x));
         chk("R10 noc_raddr", int'(noc_raddr), int'(req_raddr));
         chk("R10 noc_laddr", int'(noc_laddr), int'(req_laddr));
         chk("R10 noc_write", int'(noc_write), int'(req_write));
      end
   endtask

   // inputs are already set; let them settle, compare, then cross one edge
   task automatic cyc();
      #1;
      check_all();
      @(posedge clk);
      #1;
   endtask

   task automatic rand_fields();
      req_x = 6'($urandom); req_y = 6'($urandom); req_raddr = $urandom;
      req_laddr = 20'($urandom);
      if (in_priv(req_laddr)) req_laddr = PLIMIT + 20'd1 + 20'($urandom % 16);
   endtask

   task automatic idle();
      req_valid = 0; cpl_rd = 0; cpl_wr = 0; noc_ready = 0;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state seen at the ports
      chk("R1 rd_outstanding", int'(rd_outstanding), 0);
      chk("R1 wr_outstanding", int'(wr_outstanding), 0);
      chk("R1 priv_error", int'(priv_error), 0);
      chk("R1 barrier done", int'(rd_barrier_done | wr_barrier_done), 0);
      chk("R1 core_stall", int'(core_stall), 0);
      chk("R1 noc_valid", int'(noc_valid), 0);

      // random traffic: unordered completions, collisions, spurious completions
      for (int i = 0; i < 3000; i++) begin
         rand_fields();
         req_valid  = ($urandom % 3) != 0;
         req_write  = 1'($urandom);
         noc_ready  = ($urandom % 4) != 0;
         cpl_rd     = (m_cnt[0] > 0) ? (($urandom % 3) == 0) : (($urandom % 8) == 0);
         cpl_wr     = (m_cnt[1] > 0) ? (($urandom % 3) == 0) : (($urandom % 8) == 0);
         rd_barrier = ($urandom % 5) == 0 ? ~rd_barrier : rd_barrier;
         wr_barrier = ($urandom % 5) == 0 ? ~wr_barrier : wr_barrier;
         cyc();
      end

      // drain, then a read barrier raised at zero releases next cycle (R6)
      idle(); rd_barrier = 0; wr_barrier = 0;
      while (m_cnt[0] > 0 || m_cnt[1] > 0) begin
         cpl_rd = m_cnt[0] > 0; cpl_wr = m_cnt[1] > 0; cyc();
      end
      idle(); cyc(); cyc();
      rd_barrier = 1; cyc();
      chk("R6 done one cycle after raise", int'(rd_barrier_done), 1);
      rd_barrier = 0; cyc();

      // R5: issue and completion of reads in the same cycle
      rand_fields(); req_valid = 1; req_write = 0; noc_ready = 1; cyc();
      cpl_rd = 1;
      for (int i = 0; i < 5; i++) begin rand_fields(); cyc(); end
      chk("R5 collide keeps count", int'(rd_outstanding), 1);

      // R3: saturate the read counter
      cpl_rd = 0;
      for (int i = 0; i < 260; i++) begin rand_fields(); cyc(); end
      chk("R3 count pinned", int'(rd_outstanding), MAXC);
      #1 chk("R3 noc_valid low when full", int'(noc_valid), 0);
      chk("R3 req_ready low when full", int'(req_ready), 0);
      // R7: write barrier releases while reads are full
      req_valid = 0; wr_barrier = 1; cyc(); cyc();
      chk("R7 write barrier independent", int'(wr_barrier_done), 1);
      rd_barrier = 1; cyc(); cyc();
      chk("R9 stall held by reads", int'(core_stall), 1);
      wr_barrier = 0;
      while (m_cnt[0] > 0) begin cpl_rd = 1; cyc(); end
      cpl_rd = 0; cyc();
      chk("R6 released after drain", int'(rd_barrier_done), 1);
      chk("R9 stall gone", int'(core_stall), 0);
      rd_barrier = 0; cyc();

      // R8: private window boundaries
      noc_ready = 1; req_valid = 1; req_write = 1;
      req_laddr = PBASE - 20'd1; cyc();
      chk("R8 below base issues", int'(wr_outstanding), 1);
      chk("R8 no error yet", int'(priv_error), 0);
      req_laddr = PBASE; #1;
      chk("R8 base not forwarded", int'(noc_valid), 0);
      chk("R8 base accepted", int'(req_ready), 1);
      cyc();
      chk("R8 error set", int'(priv_error), 1);
      req_laddr = PLIMIT; noc_ready = 0; cyc();
      chk("R8 count unchanged", int'(wr_outstanding), 1);
      idle(); cyc(); cyc();
      chk("R8 error sticky", int'(priv_error), 1);

      done_run = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule